// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps calendar time as six packed-BCD byte fields: seconds, minutes, hours, day of month, month and a two-digit year. A free-running prescaler divides a 32768 Hz tick enable, which is synchronous to the system clock, down to a once-per-second advance. The carry from seconds ripples through every field on a single clock edge. Software can therefore read the fields in any order and re-read once when it sees seconds at 00.

An alarm unit compares the running time with a programmed alarm time. Only the fields whose own enable bit is set take part, and only while the global alarm enable is set. A new match sets a sticky pending bit that drives the interrupt pin. Software clears the bit by writing 1 to it. A byte-wide register port gives access to the control, alarm-control, pending, time and alarm registers.

Top module: `cal_clock`

## Requirements
- R1: After synchronous reset the time reads 00:00:00, day 01, month 01, year 00. The control, alarm-control and pending registers read 00, and `alarm_irq` is 0.
- R2: Register map:
  - 0 is control: bit0 run, bit1 prescaler hold, bit2 fast step.
  - 1 is alarm control: bit0 sec, bit1 min, bit2 hour, bit3 day, bit4 month, bit5 year, bit6 global enable.
  - 2 is pending: bit0 alarm.
  - 3 to 8 hold the time fields seconds, minutes, hours, day, month, year.
  - 9 to 14 hold the alarm fields in the same order.

  Writes take effect at the clock edge where `bus_wr` is high, and reads are combinational. If a time field is written in the same cycle as an advance, the written value wins and that advance is dropped.
- R3: With run=1, hold=0 and fast=0, the seconds field advances once every 2^PRESC_W ticks of `osc_tick`, counted from the moment hold is released.
- R4: With run=0, no field advances. With hold=1 in normal mode, the prescaler stays at zero and no field advances.
- R5: With run=1 and fast=1, every `osc_tick` pulse advances the time by exactly one second, bypassing the prescaler.
- R6: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00. Year wraps from 99 to 00. Every carried field changes on the same edge, so 23:59:59 on 31/12/99 becomes 00:00:00 on 01/01/00.
- R7: The day field wraps to 01 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. February ends at 29 when the binary year is divisible by 4, and at 28 otherwise.
- R8: The match condition is the global enable ANDed with equality on every field whose enable bit is set. Fields whose enable bits are clear are ignored.
- R9: Pending is set one cycle after the match condition goes from false to true. It is not set again while the match remains true. `alarm_irq` equals the pending bit.
- R10: Writing 1 to pending bit0 clears it, and writing 0 leaves it unchanged. When a new match and a clear meet on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse at the 32768 Hz rate |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| alarm_irq | output | 1 | Alarm interrupt, level of the pending bit |

## Verification
The alarm-pending update can coincide with a software clear of that bit. The bench arranges this by running in fast-step mode with the alarm one second ahead of the time. It pulses `osc_tick` and then issues the clear write one cycle later, so that the write lands exactly on the edge where the new match sets pending. The expected result is that pending remains 1 and a later plain clear removes it. A second coincidence, a seconds write in the same cycle as an advance, is judged by reading back the written value unchanged.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int ADDR_W  = 4;
    localparam int NFIELD  = 6;
    localparam int A_CTRL  = 0;
    localparam int A_ACTL  = 1;
    localparam int A_PEND  = 2;
    localparam int A_TIME0 = 3;
    localparam int A_ALM0  = A_TIME0 + NFIELD;

    localparam int CTL_RUN  = 0;
    localparam int CTL_HOLD = 1;
    localparam int CTL_FAST = 2;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    typedef logic [NFIELD-1:0][7:0] cal_time_t;

    typedef struct packed {
        logic              glb;
        logic [NFIELD-1:0] fld;
    } alm_ctl_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return v + 8'd1;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return ({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] year);
        logic [6:0] yb;
        yb = bcd_to_bin(year);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] field_top(input int idx, input cal_time_t t);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_DAY:        return month_last(t[F_MON], t[F_YEAR]);
            F_MON:        return 8'h12;
            default:      return 8'h99;
        endcase
    endfunction

    function automatic logic [7:0] field_base(input int idx);
        return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    output logic strobe
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold)  cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    assign strobe = tick && !hold && (&cnt_q);
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output cal_time_t  now
);
    logic [NFIELD-1:0] wrap;
    logic [NFIELD:0]   carry;

    always_comb begin
        carry[0] = adv && !wr_en;
        for (int i = 0; i < NFIELD; i++) begin
            wrap[i]      = now[i] >= field_top(i, now);
            carry[i + 1] = carry[i] && wrap[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NFIELD; i++) begin
            if (rst)
                now[i] <= field_base(i);
            else if (wr_en && (int'(wr_idx) == i))
                now[i] <= wr_data;
            else if (carry[i])
                now[i] <= wrap[i] ? field_base(i) : bcd_inc(now[i]);
        end
    end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cal_time_t now,
    input  cal_time_t alm,
    input  alm_ctl_t  ctl,
    input  logic      clr,
    output logic      fire,
    output logic      pend
);
    logic [NFIELD-1:0] hit;
    logic              match, match_q;

    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign hit[i] = !ctl.fld[i] || (now[i] == alm[i]);
    end

    assign match = ctl.glb && (&hit);
    assign fire  = match && !match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
            pend    <= 1'b0;
        end else begin
            match_q <= match;
            if (fire)     pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int PRESC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              alarm_irq
);
    logic [2:0] ctrl_q;
    alm_ctl_t   actl_q;
    cal_time_t  alm_q, now;
    logic       presc_strobe, adv, time_wr, alm_wr, pend_clr, pend, fire;
    logic       in_time, in_alm;
    logic [2:0] wr_idx, alm_idx;

    assign in_time  = (int'(bus_addr) >= A_TIME0) && (int'(bus_addr) < A_TIME0 + NFIELD);
    assign in_alm   = (int'(bus_addr) >= A_ALM0)  && (int'(bus_addr) < A_ALM0 + NFIELD);
    assign wr_idx   = 3'(bus_addr - ADDR_W'(A_TIME0));
    assign alm_idx  = 3'(bus_addr - ADDR_W'(A_ALM0));
    assign time_wr  = bus_wr && in_time;
    assign alm_wr   = bus_wr && in_alm;
    assign pend_clr = bus_wr && (int'(bus_addr) == A_PEND) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            actl_q <= '0;
            alm_q  <= '0;
        end else if (bus_wr) begin
            if (int'(bus_addr) == A_CTRL) ctrl_q <= bus_wdata[2:0];
            if (int'(bus_addr) == A_ACTL) actl_q <= bus_wdata[6:0];
            if (alm_wr)                   alm_q[alm_idx] <= bus_wdata;
        end
    end

    cal_prescaler #(.W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .tick   (osc_tick),
        .hold   (ctrl_q[CTL_HOLD]),
        .strobe (presc_strobe)
    );

    assign adv = ctrl_q[CTL_RUN] && (ctrl_q[CTL_FAST] ? osc_tick : presc_strobe);

    cal_time_core u_core (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .wr_en   (time_wr),
        .wr_idx  (wr_idx),
        .wr_data (bus_wdata),
        .now     (now)
    );

    cal_alarm u_alarm (
        .clk  (clk),
        .rst  (rst),
        .now  (now),
        .alm  (alm_q),
        .ctl  (actl_q),
        .clr  (pend_clr),
        .fire (fire),
        .pend (pend)
    );

    assign alarm_irq = pend;

    always_comb begin
        bus_rdata = 8'h00;
        if (int'(bus_addr) == A_CTRL)      bus_rdata = {5'b0, ctrl_q};
        else if (int'(bus_addr) == A_ACTL) bus_rdata = {1'b0, actl_q};
        else if (int'(bus_addr) == A_PEND) bus_rdata = {7'b0, pend};
        else if (in_time)                  bus_rdata = now[wr_idx];
        else if (in_alm)                   bus_rdata = alm_q[alm_idx];
    end
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       adv,
    input logic       time_wr,
    input logic [2:0] wr_idx,
    input logic [7:0] wdata,
    input cal_time_t  now,
    input logic       fire,
    input logic       pend,
    input logic       clr
);
    // R2: a seconds write lands in the seconds field
    p_sec_write_r2: assert property (@(posedge clk) disable iff (rst)
        (time_wr && wr_idx == 3'd0) |=> (now[F_SEC] == $past(wdata)));

    // R4: without an advance or a write nothing moves
    p_idle_still_r4: assert property (@(posedge clk) disable iff (rst)
        (!adv && !time_wr) |=> $stable(now));

    // R6: seconds wrap to 00
    p_sec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !time_wr && now[F_SEC] == 8'h59) |=> (now[F_SEC] == 8'h00));

    // R6: end-of-day carry clears seconds, minutes and hours together
    p_day_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !time_wr && now[F_SEC] == 8'h59 && now[F_MIN] == 8'h59 && now[F_HOUR] == 8'h23)
        |=> (now[F_SEC] == 8'h00 && now[F_MIN] == 8'h00 && now[F_HOUR] == 8'h00));

    // R9: a new match sets pending
    p_fire_sets_r9: assert property (@(posedge clk) disable iff (rst) fire |=> pend);

    // R9: one event per match
    p_fire_once_r9: assert property (@(posedge clk) disable iff (rst) fire |=> !fire);

    // R10: pending is sticky until cleared
    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

    // R10: a clear without a coincident match empties pending
    p_pend_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !fire) |=> !pend);
endmodule

bind cal_clock cal_clock_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .time_wr (time_wr),
    .wr_idx  (wr_idx),
    .wdata   (bus_wdata),
    .now     (now),
    .fire    (fire),
    .pend    (pend),
    .clr     (pend_clr)
);

// File: tb/tb_cal_clock.sv
module tb_cal_clock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [3:0] IRQ_PIN = 4'hF;

    typedef struct {
        logic [3:0] a;
        logic [7:0] e;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    cal_clock #(.PRESC_W(3)) dut (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    // monitor: pops expected items and compares them off the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = exp_q.pop_front();
                got = (it.a == IRQ_PIN) ? {7'b0, alarm_irq} : bus_rdata;
                tests++;
                if (got !== it.e) begin
                    fails++;
                    $display("FAIL %s addr=%0d got=%h exp=%h", it.tag, it.a, got, it.e);
                end
            end
        end
    end

    task automatic chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back('{a, e, tag});
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(4'd3, s); wr(4'd4, mi); wr(4'd5, h);
        wr(4'd6, d); wr(4'd7, mo); wr(4'd8, y);
    endtask

    task automatic chk_date(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                            input string tag);
        chk(4'd3, s, tag); chk(4'd4, mi, tag); chk(4'd5, h, tag);
        chk(4'd6, d, tag); chk(4'd7, mo, tag); chk(4'd8, y, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_date(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 reset time");
        chk(4'd0, 8'h00, "R1 ctrl");
        chk(4'd1, 8'h00, "R1 alarm ctrl");
        chk(4'd2, 8'h00, "R1 pending");
        chk(IRQ_PIN, 8'h00, "R1 irq");

        // R2 register writes and readback
        set_time(8'h21, 8'h07, 8'h14, 8'h09, 8'h30, 8'h45);
        chk_date(8'h21, 8'h07, 8'h14, 8'h09, 8'h30, 8'h45, "R2 time write");
        wr(4'd10, 8'h33);
        chk(4'd10, 8'h33, "R2 alarm field write");

        // R5 fast step, including a BCD digit carry
        wr(4'd0, 8'h05);
        set_time(8'h21, 8'h07, 8'h14, 8'h09, 8'h09, 8'h59);
        pulse();
        chk(4'd3, 8'h00, "R5 fast step sec");
        chk(4'd4, 8'h10, "R5 fast step min");
        pulse();
        chk(4'd3, 8'h01, "R5 second step");

        // R2 write beats a coincident advance
        @(negedge clk);
        osc_tick = 1'b1; bus_addr = 4'd3; bus_wdata = 8'h20; bus_wr = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0; bus_wr = 1'b0;
        chk(4'd3, 8'h20, "R2 write wins over advance");

        // R4 run clear
        wr(4'd0, 8'h04);
        pulse(); pulse();
        chk(4'd3, 8'h20, "R4 stopped");

        // R3 prescaler: 2^3 ticks per second after hold release
        wr(4'd0, 8'h03);
        wr(4'd0, 8'h01);
        for (int i = 0; i < 7; i++) pulse();
        chk(4'd3, 8'h20, "R3 before terminal count");
        pulse();
        chk(4'd3, 8'h21, "R3 at terminal count");

        // R4 prescaler hold
        wr(4'd0, 8'h03);
        for (int i = 0; i < 12; i++) pulse();
        chk(4'd3, 8'h21, "R4 hold");

        // R6 full rollover
        wr(4'd0, 8'h05);
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        pulse();
        chk_date(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R6 century wrap");

        // R7 month lengths
        set_time(8'h22, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(4'd6, 8'h01, "R7 april end day"); chk(4'd7, 8'h05, "R7 april end month");
        set_time(8'h22, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(4'd6, 8'h31, "R7 january 31");
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(4'd6, 8'h29, "R7 leap feb 29");
        set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(4'd6, 8'h01, "R7 leap feb end day"); chk(4'd7, 8'h03, "R7 leap feb end month");
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(4'd6, 8'h01, "R7 common feb end day"); chk(4'd7, 8'h03, "R7 common feb end month");

        // R8 field enables and global enable
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
        wr(4'd2, 8'h01);
        set_time(8'h10, 8'h05, 8'h05, 8'h03, 8'h04, 8'h59);
        wr(4'd10, 8'h05);
        wr(4'd11, 8'h12);
        wr(4'd1, 8'h02);
        wr(4'd0, 8'h05);
        pulse();
        chk(IRQ_PIN, 8'h00, "R8 global off");
        wr(4'd1, 8'h42);
        chk(IRQ_PIN, 8'h01, "R8 disabled hour ignored");
        chk(4'd2, 8'h01, "R9 pending bit");
        wr(4'd2, 8'h00);
        chk(IRQ_PIN, 8'h01, "R10 write 0 keeps pending");
        wr(4'd2, 8'h01);
        chk(IRQ_PIN, 8'h00, "R10 clear");
        chk(IRQ_PIN, 8'h00, "R9 no refire while matching");
        wr(4'd1, 8'h46);
        wr(4'd4, 8'h04);
        wr(4'd3, 8'h59);
        pulse();
        chk(IRQ_PIN, 8'h00, "R8 enabled hour mismatch");

        // R10 set and clear on the same edge
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
        wr(4'd2, 8'h01);
        wr(4'd3, 8'h30);
        wr(4'd9, 8'h31);
        wr(4'd1, 8'h41);
        chk(IRQ_PIN, 8'h00, "R10 idle before collision");
        wr(4'd0, 8'h05);
        @(negedge clk);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0; bus_addr = 4'd2; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(IRQ_PIN, 8'h01, "R10 set wins over clear");
        wr(4'd2, 8'h01);
        chk(IRQ_PIN, 8'h00, "R10 later clear");
        pulse();
        chk(IRQ_PIN, 8'h00, "R9 past the match");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule